// File: doc/BRIEF.md
# Monotonic Boot Isolation Level Controller

This block keeps a small counter that names the isolation level a chip is booting at. Each boot stage may move the counter upward before it hands control to the next stage. No command moves it back down. Only a power-on reset or a system reset returns it to zero. Software issues commands over a valid/ready command port and reads the current level and a sticky violation flag as plain status pins.

A second, purely combinational port answers access questions. It takes a decoded memory region class and an access type, and returns allow or deny according to the current level. Each level beyond zero closes off the region that belonged to the earlier stage, and the restrictions add up as the level rises. A level change is visible on this port in the cycle that follows the accepted command.

The command port follows a valid/ready rule. A command is taken on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low while either reset is asserted and high at all other times, so the block applies back-pressure only during reset. A requester may hold `cmd_valid` and its fields for as long as it likes. Each edge where both signals are high counts as one more command.

Top module: `iso_level_ctrl`

## Requirements
- R1: While either reset input is low, and right after both are released, `cur_level` is 0 and `violation` is 0. Reset may be asserted at any time and takes effect asynchronously.
- R2: An accepted command with `cmd_op`=0 (raise) and `cmd_key` equal to the KEY parameter (default 8'hA5) raises `cur_level` by exactly one, visible after that clock edge, as long as the level is below its maximum.
- R3: An accepted command whose `cmd_key` differs from KEY leaves `cur_level` unchanged and sets `violation`.
- R4: An accepted raise command with a valid key while the level is at its maximum (3) leaves the level at 3 and sets `violation`.
- R5: An accepted command with `cmd_op`=1 (set) and a valid key moves the level to `cmd_level` when `cmd_level` is greater than or equal to the current level. When `cmd_level` is lower than the current level, the level is unchanged and `violation` is set.
- R6: Once set, `violation` stays high until a reset, whatever commands follow.
- R7: Between resets, `cur_level` never decreases.
- R8: System-flash region (`chk_region`=0): a read (`chk_type`=0) or an execute (`chk_type`=2) is allowed only at level 0. A write (`chk_type`=1) is always denied.
- R9: User-flash region (`chk_region`=1): read, write and execute are allowed at every level.
- R10: Protected option-defined region (`chk_region`=2): read, write and execute are allowed only while the level is below 2.
- R11: Extended protected sectors (`chk_region`=3): read, write and execute are allowed only while the level is below 3.
- R12: Access type code 3 is reserved and is always denied.
- R13: `cmd_ready` is 0 while a reset is asserted and 1 otherwise. A command with `cmd_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 1 | 0 = raise by one, 1 = set to `cmd_level` |
| cmd_key | input | 8 | Authorisation key that accompanies the command |
| cmd_level | input | 2 | Target level for a set command |
| cur_level | output | 2 | Current isolation level |
| violation | output | 1 | Sticky flag for a rejected command |
| chk_region | input | 2 | Region class: 0 system flash, 1 user flash, 2 protected option area, 3 extended protected sectors |
| chk_type | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| chk_allow | output | 1 | 1 when the access is allowed |

## Verification
The command path is driven with five kinds of command:
- a valid raise, which checks the single step;
- a wrong key, which checks that it is rejected;
- a raise at the top level, which checks that the level saturates;
- a set to a lower level, which checks that the level holds and the flag is raised;
- a set that jumps upward, which checks that a multi-level step is legal.

Idle cycles are also driven with a good key but `cmd_valid` low, to show that an unqualified key does nothing.

At each of the four levels the access port is swept over all region and type combinations. This shows which regions each level has closed and that the restrictions add up. The write rule for system flash and the reserved type code are visible separately in the same sweep.

Both reset inputs are pulsed after the flag has been set and the level raised. This shows that either reset alone clears the level and the flag, and that `cmd_ready` is low while reset is held.

// File: rtl/iso_pkg.sv
package iso_pkg;

  typedef enum logic [1:0] {
    RG_SYSFLASH = 2'd0,
    RG_USERFLASH = 2'd1,
    RG_OPTAREA = 2'd2,
    RG_EXTSECT = 2'd3
  } iso_region_e;

  typedef enum logic [1:0] {
    AC_READ = 2'd0,
    AC_WRITE = 2'd1,
    AC_EXEC = 2'd2,
    AC_RSVD = 2'd3
  } iso_access_e;

  localparam logic OP_RAISE = 1'b0;
  localparam logic OP_SET = 1'b1;

  localparam int NUM_REGIONS = 4;

  // Level at which a region becomes closed; -1 means never closes.
  function automatic int close_level(input int region);
    case (region)
      0: close_level = 1;
      1: close_level = -1;
      2: close_level = 2;
      default: close_level = 3;
    endcase
  endfunction

endpackage

// File: rtl/iso_cmd_decode.sv
module iso_cmd_decode #(
  parameter int LEVEL_W = 2,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic               fire,
  input  logic               op,
  input  logic [KEY_W-1:0]   key,
  input  logic [LEVEL_W-1:0] target,
  input  logic [LEVEL_W-1:0] level,
  output logic               upd,
  output logic [LEVEL_W-1:0] nxt_level,
  output logic               viol_set
);
  import iso_pkg::*;

  localparam logic [LEVEL_W-1:0] MAX_LEVEL = {LEVEL_W{1'b1}};

  logic key_ok;
  assign key_ok = (key == KEY);

  always_comb begin
    upd = 1'b0;
    viol_set = 1'b0;
    nxt_level = level;
    if (fire) begin
      if (!key_ok) begin
        viol_set = 1'b1;
      end else if (op == OP_RAISE) begin
        if (level == MAX_LEVEL) begin
          viol_set = 1'b1;
        end else begin
          upd = 1'b1;
          nxt_level = level + 1'b1;
        end
      end else begin
        if (target < level) begin
          viol_set = 1'b1;
        end else if (target != level) begin
          upd = 1'b1;
          nxt_level = target;
        end
      end
    end
  end

  // R7: any update the decoder requests moves the level strictly upward
  always_comb begin
    if (upd) begin
      p_upward_only_r7 : assert (nxt_level > level);
    end
  end

endmodule

// File: rtl/iso_level_reg.sv
module iso_level_reg #(
  parameter int LEVEL_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic [LEVEL_W-1:0] nxt_level,
  input  logic               viol_set,
  output logic [LEVEL_W-1:0] level,
  output logic               viol
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      viol <= 1'b0;
    end else begin
      if (upd) level <= nxt_level;
      if (viol_set) viol <= 1'b1;
    end
  end

  p_no_decrease_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    level >= $past(level));

  p_sticky_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(viol) |-> viol);

  p_hold_without_upd_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd) |-> level == $past(level));

endmodule

// File: rtl/iso_access_check.sv
module iso_access_check #(
  parameter int LEVEL_W = 2
) (
  input  logic [LEVEL_W-1:0] level,
  input  logic [1:0]         region,
  input  logic [1:0]         acc_type,
  output logic               allow
);
  import iso_pkg::*;

  logic [NUM_REGIONS-1:0] region_open;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    localparam int CLOSE_AT = close_level(r);
    if (CLOSE_AT < 0) begin : g_always_open
      assign region_open[r] = 1'b1;
    end else begin : g_closes
      assign region_open[r] = (int'(level) < CLOSE_AT);
    end
  end

  logic sys_write;
  assign sys_write = (region == RG_SYSFLASH) && (acc_type == AC_WRITE);

  assign allow = (acc_type != AC_RSVD) && region_open[region] && !sys_write;

endmodule

// File: rtl/iso_level_ctrl.sv
module iso_level_ctrl #(
  parameter int LEVEL_W = 2,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sys_rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_op,
  input  logic [KEY_W-1:0]   cmd_key,
  input  logic [LEVEL_W-1:0] cmd_level,
  output logic [LEVEL_W-1:0] cur_level,
  output logic               violation,
  input  logic [1:0]         chk_region,
  input  logic [1:0]         chk_type,
  output logic               chk_allow
);
  import iso_pkg::*;

  localparam logic [LEVEL_W-1:0] MAX_LEVEL = {LEVEL_W{1'b1}};

  logic rst_n;
  logic fire;
  logic upd;
  logic viol_set;
  logic [LEVEL_W-1:0] nxt_level;

  assign rst_n = por_n & sys_rst_n;
  assign cmd_ready = rst_n;
  assign fire = cmd_valid & cmd_ready;

  iso_cmd_decode #(.LEVEL_W(LEVEL_W), .KEY_W(KEY_W), .KEY(KEY)) u_dec (
    .fire(fire), .op(cmd_op), .key(cmd_key), .target(cmd_level),
    .level(cur_level), .upd(upd), .nxt_level(nxt_level), .viol_set(viol_set)
  );

  iso_level_reg #(.LEVEL_W(LEVEL_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .upd(upd), .nxt_level(nxt_level),
    .viol_set(viol_set), .level(cur_level), .viol(violation)
  );

  iso_access_check #(.LEVEL_W(LEVEL_W)) u_chk (
    .level(cur_level), .region(chk_region), .acc_type(chk_type),
    .allow(chk_allow)
  );

  p_bad_key_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_key != KEY) |=> violation && $stable(cur_level));

  p_saturate_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_key == KEY && cmd_op == OP_RAISE && cur_level == MAX_LEVEL)
      |=> cur_level == MAX_LEVEL && violation);

  p_no_lower_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SET && cmd_level < cur_level)
      |=> $stable(cur_level) && violation);

  p_raise_step_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_key == KEY && cmd_op == OP_RAISE && cur_level != MAX_LEVEL)
      |=> cur_level == $past(cur_level) + 1'b1);

  p_sys_closed_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level != '0 && chk_region == RG_SYSFLASH) |-> !chk_allow);

  p_opt_closed_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cur_level) >= 2 && chk_region == RG_OPTAREA) |-> !chk_allow);

  p_rsvd_deny_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    (chk_type == AC_RSVD) |-> !chk_allow);

endmodule

// File: tb/test_iso_level_ctrl.sv
module test_iso_level_ctrl;

  localparam logic [7:0] GOOD = 8'hA5;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic sys_rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic cmd_op = 1'b0;
  logic [7:0] cmd_key = 8'h00;
  logic [1:0] cmd_level = 2'd0;
  logic [1:0] cur_level;
  logic violation;
  logic [1:0] chk_region = 2'd0;
  logic [1:0] chk_type = 2'd0;
  logic chk_allow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  iso_level_ctrl i_iso_level_ctrl (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_key(cmd_key), .cmd_level(cmd_level), .cur_level(cur_level),
    .violation(violation), .chk_region(chk_region), .chk_type(chk_type),
    .chk_allow(chk_allow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_allow(input int lvl, input int rg, input int ty);
    if (ty == 3) return 1'b0;                  // R12
    case (rg)
      0: return (lvl == 0) && (ty != 1);        // R8
      1: return 1'b1;                           // R9
      2: return lvl < 2;                        // R10
      default: return lvl < 3;                  // R11
    endcase
  endfunction

  task automatic send(input logic op, input logic [7:0] key, input logic [1:0] tgt);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_key = key;
    cmd_level = tgt;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic sweep_access(input int lvl);
    for (int rg = 0; rg < 4; rg++) begin
      for (int ty = 0; ty < 4; ty++) begin
        chk_region = 2'(rg);
        chk_type = 2'(ty);
        #1;
        check($sformatf("R8-R12 access lvl=%0d rg=%0d ty=%0d", lvl, rg, ty),
              int'(chk_allow), int'(exp_allow(lvl, rg, ty)));
      end
    end
  endtask

  task automatic t_reset;
    por_n = 1'b0;
    sys_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R13 ready low in reset", int'(cmd_ready), 0);
    check("R1 level in reset", int'(cur_level), 0);
    por_n = 1'b1;
    sys_rst_n = 1'b1;
    @(negedge clk);
    check("R1 level after reset", int'(cur_level), 0);
    check("R1 flag after reset", int'(violation), 0);
    check("R13 ready after reset", int'(cmd_ready), 1);
  endtask

  task automatic t_raise_and_sweep;
    sweep_access(0);
    for (int l = 1; l <= 3; l++) begin
      send(1'b0, GOOD, 2'd0);
      check("R2 raise by one", int'(cur_level), l);
      check("R2 no flag on good raise", int'(violation), 0);
      sweep_access(l);
    end
  endtask

  task automatic t_saturate;
    send(1'b0, GOOD, 2'd0);
    check("R4 level stays at max", int'(cur_level), 3);
    check("R4 flag on saturation", int'(violation), 1);
  endtask

  task automatic t_idle_key;
    // cmd_valid low with a good key must not move the level
    @(negedge clk);
    cmd_key = GOOD;
    cmd_op = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 no effect without valid", int'(cur_level), 0);
    check("R13 no flag without valid", int'(violation), 0);
  endtask

  task automatic t_bad_key;
    send(1'b0, 8'h5A, 2'd0);
    check("R3 level unchanged on bad key", int'(cur_level), 0);
    check("R3 flag on bad key", int'(violation), 1);
    send(1'b0, GOOD, 2'd0);
    check("R2 raise after bad key", int'(cur_level), 1);
    check("R6 flag stays set", int'(violation), 1);
  endtask

  task automatic t_set;
    send(1'b1, GOOD, 2'd2);
    check("R5 set jumps up", int'(cur_level), 2);
    check("R5 no flag on upward set", int'(violation), 0);
    send(1'b1, GOOD, 2'd2);
    check("R5 set same level", int'(cur_level), 2);
    check("R5 no flag on equal set", int'(violation), 0);
    send(1'b1, GOOD, 2'd1);
    check("R5 lower set ignored", int'(cur_level), 2);
    check("R5 flag on lower set", int'(violation), 1);
    send(1'b1, GOOD, 2'd3);
    check("R5 set upward after flag", int'(cur_level), 3);
    check("R6 flag still set", int'(violation), 1);
  endtask

  task automatic sys_reset_pulse;
    @(negedge clk);
    sys_rst_n = 1'b0;
    #3;
    check("R1 async system reset level", int'(cur_level), 0);
    check("R1 async system reset flag", int'(violation), 0);
    check("R13 ready low in system reset", int'(cmd_ready), 0);
    @(negedge clk);
    sys_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic por_pulse;
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    check("R1 power-on reset level", int'(cur_level), 0);
    check("R1 power-on reset flag", int'(violation), 0);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_key();
    t_raise_and_sweep();
    t_saturate();
    sys_reset_pulse();
    t_bad_key();
    por_pulse();
    t_set();
    por_pulse();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule